// File: doc/BRIEF.md
# Serial Front-End Command Shifter

This block sends register commands from a host to a remote front-end chip over a slow two-wire serial link and collects the reply. The host offers a command made of a chip address, a read/write flag, a register number and a 16-bit data word, using a valid/ready handshake. The block then produces a serial clock and a command data line, and ends the command with an odd-parity bit. It next shifts 16 reply bits in from a return line and presents the captured word with a one-cycle done pulse.

Each serial bit lasts four system-clock cycles: two with the serial clock low and two with it high. The data line changes only while the clock is low. The return line is sampled in the system cycle just before a serial rising edge, which gives the remote chip an extra cycle to settle. The parity bit is still held through its own rising edge. An optional fix-up mode sacrifices data bit 15, which the remote chip does not use, so that the transmitted parity bit is always zero. In that mode bit 15 is also removed from every returned word.

Top module: `fe_cmd_shifter`

## Requirements
- R1: After a synchronous active-high reset, cmdReady is 1 and sclk, sdo and rdDone are 0.
- R2: A command is taken on a rising clock edge where cmdValid and cmdReady are both 1. cmdReady is then 0 until the cycle in which rdDone is 1. While cmdReady is 0, cmdValid and all command inputs are ignored.
- R3: The frame has 27 bits, sent MSB first in this order: cmdAddr[4:0], cmdRead, cmdReg[3:0], data[15:0], parity. Each bit takes 4 system cycles: sclk is low for 2 cycles, then high for 2.
- R4: sdo changes only while sclk is low, so the parity bit stays on sdo through its own rising edge. sdo is 0 during the readback phase and while idle.
- R5: The parity bit is 1 exactly when the 26 bits before it contain an even number of ones (odd parity).
- R6: When fixParity is 1 at acceptance, the data bit 15 that is sent is 1 exactly when cmdAddr, cmdRead, cmdReg and cmdData[14:0] together hold an even number of ones. The parity bit sent is then 0.
- R7: After the frame come 16 more sclk periods with sdo at 0. In each, sdi is sampled in the system cycle just before the sclk rising edge, and the bits are assembled MSB first.
- R8: If fixParity was 1 at acceptance, bit 15 of rdData is 0. Otherwise rdData holds all 16 captured bits.
- R9: rdDone is 1 for exactly one cycle, with rdData valid in that cycle. rdDone is high in the cycle after the 172nd rising clock edge that follows the accepting edge.
- R10: sclk is low while idle, and each command produces exactly 43 sclk rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdAddr | input | 5 | Remote chip address |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdReg | input | 4 | Register number |
| cmdData | input | 16 | Command data word |
| fixParity | input | 1 | Fix-up mode: force parity bit to zero |
| sclk | output | 1 | Serial clock to the front end |
| sdo | output | 1 | Serial command data |
| sdi | input | 1 | Serial return data |
| rdData | output | 16 | Captured readback word |
| rdDone | output | 1 | One-cycle pulse, rdData valid |

## Verification
Random commands are sent with fix-up mode both on and off. This exposes errors in field order and in either parity rule, because each decoded frame is compared with a frame computed by the bench. Directed commands carrying the word 0x0020, with readback 0x8020, separate the masked readback from the unmasked one. All-ones readback in normal mode shows that bit 15 is kept when fix-up is off. The bench's return-line model inverts sdi just after every sclk rising edge, so sampling one cycle late gives the wrong word. One command keeps cmdValid high with different fields while the block is busy; this shows that busy-time input is ignored and that the ready and done timing holds.

// File: rtl/fe_cmd_pkg.sv
package fe_cmd_pkg;
  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;       // take a new command
    logic shiftTx;    // advance to next command bit
    logic capture;    // shift one return bit in
    logic finish;     // publish readback word
    logic sendPhase;  // command bits are on the line
  } strobe_t;
endpackage

// File: rtl/fe_cmd_ctrl.sv
module fe_cmd_ctrl
  import fe_cmd_pkg::*;
#(
  parameter int FRAME_W   = 27,
  parameter int READ_W    = 16,
  parameter int PHASE_CYC = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmdValid,
  output logic    cmdReady,
  output logic    sclk,
  output strobe_t strobe
);
  localparam int PH_W  = $clog2(PHASE_CYC);
  localparam int CNT_W = $clog2((FRAME_W > READ_W) ? FRAME_W : READ_W);
  localparam int HALF  = PHASE_CYC / 2;
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(PHASE_CYC - 1);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0]  PH_HIGH   = PH_W'(HALF);
  localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] RX_LAST   = CNT_W'(READ_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_READ} state_t;

  state_t          state;
  logic [PH_W-1:0] phase;
  logic [CNT_W-1:0] bitCnt;
  logic            phaseEnd;

  assign phaseEnd = (phase == PH_LAST);
  assign cmdReady = (state == S_IDLE);
  assign sclk     = (state != S_IDLE) && (phase >= PH_HIGH);

  always_comb begin
    strobe           = '0;
    strobe.load      = (state == S_IDLE) && cmdValid;
    strobe.shiftTx   = (state == S_SEND) && phaseEnd && (bitCnt != TX_LAST);
    strobe.capture   = (state == S_READ) && (phase == PH_SAMPLE);
    strobe.finish    = (state == S_READ) && phaseEnd && (bitCnt == RX_LAST);
    strobe.sendPhase = (state == S_SEND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      phase  <= '0;
      bitCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          phase  <= '0;
          bitCnt <= '0;
          if (cmdValid) state <= S_SEND;
        end
        S_SEND: begin
          phase <= phaseEnd ? '0 : phase + 1'b1;
          if (phaseEnd) begin
            if (bitCnt == TX_LAST) begin
              state  <= S_READ;
              bitCnt <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        S_READ: begin
          phase <= phaseEnd ? '0 : phase + 1'b1;
          if (phaseEnd) begin
            if (bitCnt == RX_LAST) state <= S_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmdValid && cmdReady) |=> !cmdReady); // R2
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmdReady |-> !sclk); // R10
endmodule

// File: rtl/fe_cmd_datapath.sv
module fe_cmd_datapath
  import fe_cmd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int REG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdRead,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              fixParity,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  localparam int LOW_W   = ADDR_W + 1 + REG_W + DATA_W - 1;
  localparam int FRAME_W = LOW_W + 2;

  logic [LOW_W-1:0]   lowFields;
  logic               dataTop;
  logic [FRAME_W-2:0] body;
  logic [FRAME_W-1:0] txShift;
  logic [DATA_W-1:0]  rxShift;
  logic               fixLatched;

  // Fields other than data bit 15
  assign lowFields = {cmdAddr, cmdRead, cmdReg, cmdData[DATA_W-2:0]};
  assign dataTop   = fixParity ? ~^lowFields : cmdData[DATA_W-1];
  assign body      = {cmdAddr, cmdRead, cmdReg, dataTop, cmdData[DATA_W-2:0]};
  assign sdo       = strobe.sendPhase & txShift[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      txShift    <= '0;
      rxShift    <= '0;
      fixLatched <= 1'b0;
      rdData     <= '0;
      rdDone     <= 1'b0;
    end else begin
      rdDone <= strobe.finish;
      if (strobe.load) begin
        txShift    <= {body, ~^body};
        fixLatched <= fixParity;
      end else if (strobe.shiftTx) begin
        txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (strobe.capture) rxShift <= {rxShift[DATA_W-2:0], sdi};
      if (strobe.finish)
        rdData <= fixLatched ? {1'b0, rxShift[DATA_W-2:0]} : rxShift;
    end
  end

  AST_FIX_PARITY: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && fixParity) |=> !txShift[0]); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rdDone |=> !rdDone); // R9
  AST_RDATA_MASK: assert property (@(posedge clk) disable iff (rst)
    (rdDone && fixLatched) |-> !rdData[DATA_W-1]); // R8
endmodule

// File: rtl/fe_cmd_shifter.sv
module fe_cmd_shifter
  import fe_cmd_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int REG_W     = 4,
  parameter int DATA_W    = 16,
  parameter int PHASE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              cmdRead,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              fixParity,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [DATA_W-1:0] rdData,
  output logic              rdDone
);
  localparam int FRAME_W = ADDR_W + 1 + REG_W + DATA_W + 1;

  strobe_t strobe;

  fe_cmd_ctrl #(
    .FRAME_W(FRAME_W), .READ_W(DATA_W), .PHASE_CYC(PHASE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .sclk(sclk), .strobe(strobe)
  );

  fe_cmd_datapath #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cmdAddr(cmdAddr),
    .cmdRead(cmdRead), .cmdReg(cmdReg), .cmdData(cmdData),
    .fixParity(fixParity), .sdi(sdi), .sdo(sdo), .rdData(rdData),
    .rdDone(rdDone)
  );

  AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo)); // R4
  AST_SDO_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmdReady |-> !sdo); // R4
endmodule

// File: tb/fe_cmd_shifter_bench.sv
module fe_cmd_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [4:0]  cmdAddr = '0;
  logic        cmdRead = 1'b0;
  logic [3:0]  cmdReg = '0;
  logic [15:0] cmdData = '0;
  logic        fixParity = 1'b0;
  logic        sclk, sdo;
  logic        sdi = 1'b0;
  logic [15:0] rdData;
  logic        rdDone;

  int checks = 0;
  int errors = 0;
  int riseCnt = 0;
  int fallCnt = 0;
  logic [26:0] frameBits = '0;
  logic [15:0] rbWord = '0;

  always #10 clk = ~clk;

  fe_cmd_shifter u_fe_cmd_shifter (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdRead(cmdRead), .cmdReg(cmdReg),
    .cmdData(cmdData), .fixParity(fixParity), .sclk(sclk), .sdo(sdo),
    .sdi(sdi), .rdData(rdData), .rdDone(rdDone)
  );

  // Front-end model: record sdo after each rise, then spoil sdi (R7)
  always begin
    @(posedge sclk);
    #1;
    if (riseCnt < 27) frameBits = {frameBits[25:0], sdo};
    riseCnt++;
    sdi = ~sdi;
  end

  always begin
    @(negedge sclk);
    #1;
    fallCnt++;
    if (fallCnt >= 27 && fallCnt <= 42) sdi = rbWord[15 - (fallCnt - 27)];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [26:0] expFrame(input logic [4:0] a, input logic r,
      input logic [3:0] g, input logic [15:0] d, input logic fx);
    logic [24:0] low;
    logic [25:0] bod;
    low = {a, r, g, d[14:0]};
    if (fx) d[15] = ((^low) == 1'b0);
    bod = {a, r, g, d};
    return {bod, ((^bod) == 1'b0)};
  endfunction

  task automatic runCmd(input logic [4:0] a, input logic r, input logic [3:0] g,
      input logic [15:0] d, input logic fx, input logic [15:0] rb,
      input bit holdOff);
    logic [26:0] exp;
    int lat;
    bit busyBad;
    exp = expFrame(a, r, g, d, fx);
    @(negedge clk);
    cmdAddr = a; cmdRead = r; cmdReg = g; cmdData = d; fixParity = fx;
    cmdValid = 1'b1;
    riseCnt = 0; fallCnt = 0; rbWord = rb; sdi = 1'b0;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (holdOff) begin
      cmdAddr = ~a; cmdRead = ~r; cmdReg = ~g; cmdData = ~d; fixParity = ~fx;
    end else begin
      cmdValid = 1'b0;
    end
    lat = 0;
    busyBad = 0;
    while (!rdDone && lat < 1000) begin
      if (cmdReady) busyBad = 1;
      lat++;
      @(negedge clk);
    end
    cmdValid = 1'b0;
    check(!busyBad, "R2 ready low while busy", 32'(busyBad), 0);
    check(lat == 172, "R9 done latency", 32'(lat), 172);
    check(frameBits[26:1] == exp[26:1], "R3 frame fields", 32'(frameBits), 32'(exp));
    check(frameBits[0] == exp[0], "R5 parity bit", 32'(frameBits[0]), 32'(exp[0]));
    if (fx) check(frameBits[0] == 1'b0, "R6 fix-up parity zero", 32'(frameBits[0]), 0);
    check(rdData == (fx ? (rb & 16'h7fff) : rb), "R7 R8 readback word",
          32'(rdData), 32'(fx ? (rb & 16'h7fff) : rb));
    check(riseCnt == 43, "R10 sclk rising edges", 32'(riseCnt), 43);
    check(!sdo && !sclk, "R4 line quiet at done", {30'd0, sclk, sdo}, 0);
    @(negedge clk);
    check(!rdDone, "R9 done single pulse", 32'(rdDone), 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmdReady && !sclk && !sdo && !rdDone, "R1 reset state",
          {28'd0, cmdReady, sclk, sdo, rdDone}, 32'h8);
    rst = 1'b0;
    @(negedge clk);
    check(cmdReady, "R1 ready after reset", 32'(cmdReady), 1);
    // Directed corner cases
    runCmd(5'h03, 1'b0, 4'h2, 16'h0020, 1'b1, 16'h8020, 0); // R8 masked
    runCmd(5'h1f, 1'b1, 4'hf, 16'h0020, 1'b1, 16'hffff, 0); // R6
    runCmd(5'h00, 1'b1, 4'h0, 16'h0000, 1'b0, 16'hffff, 0); // R8 unmasked
    runCmd(5'h15, 1'b0, 4'ha, 16'h5a5a, 1'b0, 16'ha5a5, 1); // R2 hold-off
    runCmd(5'h0a, 1'b1, 4'h5, 16'hffff, 1'b1, 16'h0001, 0);
    // Random commands
    for (int i = 0; i < 20; i++) begin
      runCmd(5'($urandom), 1'($urandom), 4'($urandom), 16'($urandom),
             1'($urandom), 16'($urandom), bit'($urandom_range(0, 3) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule